// File: doc/BRIEF.md
# CAN Frame Error Status Unit

This unit sits beside a CAN protocol engine and gathers its frame-level error events into a single set of registers. There are six events: pre-buffer overflow, arbitration lost, bus error, bus-off, error warning and error passive. Each event sets a sticky status flag. A matching enable register masks the flags onto one frame-error interrupt line. Event detection is not part of this unit. The engine delivers each event as a one-cycle pulse, together with any data the event carries.

The unit also holds the transmit and receive error counters and the error warning limit. It has two capture registers. One records the identifier bit position at which arbitration was lost. The other records the code and frame position of the latest bus error. Each capture register takes one sample and then freezes. Reading it through the byte register interface re-arms it and also clears the matching status flag. The other four flags are cleared by writing 1 to them.

Software reaches the unit through a byte-wide register port. The port has a write strobe, a read strobe and a 3-bit address. Read data is combinational from the addressed register.

Top module: `frerr_unit`

## Requirements
- R1: After reset, the status, enable, transmit counter, receive counter and both capture registers read 00h. The error warning limit reads 96h and the interrupt is low. The address map is: 0 status, 1 enable, 2 transmit counter, 3 receive counter, 4 warning limit, 5 error code capture, 6 arbitration capture.
- R2: Status bit positions are: bit 5 pre-buffer overflow, bit 4 arbitration lost, bit 3 bus error, bit 2 bus-off, bit 1 error warning, bit 0 error passive. An event pulse sets its bit, and bits 7:6 read 0. The enable register uses the same positions.
- R3: Writing 1 to status bit 5, 2, 1 or 0 clears that bit. Writing 1 to bit 4 or bit 3 has no effect.
- R4: The arbitration-lost flag clears only on a strobed read of address 6. The bus-error flag clears only on a strobed read of address 5.
- R5: Each capture register latches the data of the first event that arrives while it is armed, then ignores further events. A strobed read of the register re-arms it.
- R6: The error code capture holds the 2-bit error code in bits 7:6 and the 6-bit frame state in bits 5:0. The arbitration capture holds the 5-bit bit position in bits 4:0, with bits 7:5 zero.
- R7: The interrupt is high exactly when some status bit and its enable bit are both 1.
- R8: The transmit and receive counters accept writes only while the core-reset-mode input is high. At other times, writes to them are ignored.
- R9: A bus-off event presets the transmit counter to 128 and clears the receive counter to 0. This takes precedence over a counter write in the same cycle.
- R10: When an event and a clear (a write of 1, or a capture read) act on the same flag in the same cycle, the flag ends up set. A capture read that meets its own event in the same cycle leaves the new event's data captured and the register frozen.
- R11: The error warning limit is writable at any time and reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_reset_mode_i | input | 1 | High while the protocol core is in reset mode |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on capture registers) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of addressed register |
| ev_prebuf_ovf_i | input | 1 | Pre-buffer overflow event pulse |
| ev_arb_lost_i | input | 1 | Arbitration lost event pulse |
| arb_pos_i | input | 5 | Identifier bit position with arbitration lost event |
| ev_bus_err_i | input | 1 | Bus error event pulse |
| berr_code_i | input | 2 | Bus error code with bus error event |
| berr_state_i | input | 6 | Frame position state with bus error event |
| ev_bus_off_i | input | 1 | Bus-off entry event pulse |
| ev_err_warn_i | input | 1 | Error warning event pulse |
| ev_err_pass_i | input | 1 | Error passive event pulse |
| irq_o | output | 1 | Frame-error interrupt |

## Verification
Three pairs of functions can fall in the same cycle. First, an event pulse and the software clear of that same flag: a write of 1 for the pre-buffer overflow flag, or a strobed read of the arbitration capture for the arbitration flag. Second, a capture read and a new capture event. Third, a bus-off event and a software write to the transmit counter. The bench drives each pair on a single falling edge, so both land on the same rising edge. It then reads the flag, the capture value and the counter, and expects the event to win in every case: the flag stays set, the capture holds the new data and is frozen, and the counter holds 128.

// File: rtl/frerr_pkg.sv
package frerr_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NFLAG   = 6;
    localparam int ARB_W   = 5;
    localparam int CODE_W  = 2;
    localparam int STATE_W = DATA_W - CODE_W;

    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
    localparam logic [ADDR_W-1:0] A_TXCNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RXCNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_WLIMIT = 3'd4;
    localparam logic [ADDR_W-1:0] A_CODCAP = 3'd5;
    localparam logic [ADDR_W-1:0] A_ARBCAP = 3'd6;

    localparam int F_PBO  = 5;
    localparam int F_ARB  = 4;
    localparam int F_BERR = 3;
    localparam int F_BOFF = 2;
    localparam int F_WARN = 1;
    localparam int F_PASS = 0;

    localparam logic [NFLAG-1:0]  W1C_MASK   = 6'b10_0111;
    localparam logic [DATA_W-1:0] WLIMIT_RST = 8'h96;
    localparam logic [DATA_W-1:0] TX_BOFF    = 8'd128;
endpackage

// File: rtl/frerr_capture.sv
module frerr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_i,
    input  logic [W-1:0] data_i,
    input  logic         rd_i,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic         armed;
        logic [W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (rd_i) cap_d.armed = 1'b1;
        if (ev_i && (cap_q.armed || rd_i)) begin
            cap_d.data  = data_i;
            cap_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '{armed: 1'b1, data: '0};
        else        cap_q <= cap_d;
    end

    assign data_o = cap_q.data;

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_q.armed && !rd_i) |=> $stable(data_o));
    // R5
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !ev_i) |=> cap_q.armed);
    // R10
    latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && (cap_q.armed || rd_i)) |=> (!cap_q.armed && data_o == $past(data_i)));
endmodule

// File: rtl/frerr_flags.sv
module frerr_flags
    import frerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    input  logic             en_wr_i,
    input  logic [NFLAG-1:0] en_data_i,
    output logic [NFLAG-1:0] status_o,
    output logic [NFLAG-1:0] enable_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [NFLAG-1:0] status;
        logic [NFLAG-1:0] enable;
    } flg_t;

    flg_t flg_d, flg_q;

    always_comb begin
        flg_d        = flg_q;
        flg_d.status = (flg_q.status & ~clr_i) | set_i;
        if (en_wr_i) flg_d.enable = en_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign status_o = flg_q.status;
    assign enable_o = flg_q.enable;
    assign irq_o    = |(flg_q.status & flg_q.enable);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));
    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((status_o & ~$past(status_o)) == '0));
endmodule

// File: rtl/frerr_counters.sv
module frerr_counters
    import frerr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_reset_mode_i,
    input  logic              bus_off_i,
    input  logic              wr_tx_i,
    input  logic              wr_rx_i,
    input  logic              wr_lim_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] tx_o,
    output logic [DATA_W-1:0] rx_o,
    output logic [DATA_W-1:0] lim_o
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] lim;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_lim_i) cnt_d.lim = wdata_i;
        if (core_reset_mode_i && wr_tx_i) cnt_d.tx = wdata_i;
        if (core_reset_mode_i && wr_rx_i) cnt_d.rx = wdata_i;
        if (bus_off_i) begin
            cnt_d.tx = TX_BOFF;
            cnt_d.rx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '{tx: '0, rx: '0, lim: WLIMIT_RST};
        else        cnt_q <= cnt_d;
    end

    assign tx_o  = cnt_q.tx;
    assign rx_o  = cnt_q.rx;
    assign lim_o = cnt_q.lim;

    // R9
    bus_off_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off_i |=> (tx_o == TX_BOFF && rx_o == '0));
    // R8
    locked_counters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_reset_mode_i && !bus_off_i) |=> ($stable(tx_o) && $stable(rx_o)));
endmodule

// File: rtl/frerr_unit.sv
module frerr_unit
    import frerr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_reset_mode_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              ev_prebuf_ovf_i,
    input  logic              ev_arb_lost_i,
    input  logic [ARB_W-1:0]  arb_pos_i,
    input  logic              ev_bus_err_i,
    input  logic [CODE_W-1:0] berr_code_i,
    input  logic [STATE_W-1:0] berr_state_i,
    input  logic              ev_bus_off_i,
    input  logic              ev_err_warn_i,
    input  logic              ev_err_pass_i,
    output logic              irq_o
);
    logic [NFLAG-1:0]  set_vec, clr_vec, status, enable;
    logic              rd_arb, rd_cod;
    logic [ARB_W-1:0]  arb_cap;
    logic [DATA_W-1:0] cod_cap, tx_cnt, rx_cnt, lim;

    assign rd_arb = rd_en_i && (addr_i == A_ARBCAP);
    assign rd_cod = rd_en_i && (addr_i == A_CODCAP);

    always_comb begin
        set_vec         = '0;
        set_vec[F_PBO]  = ev_prebuf_ovf_i;
        set_vec[F_ARB]  = ev_arb_lost_i;
        set_vec[F_BERR] = ev_bus_err_i;
        set_vec[F_BOFF] = ev_bus_off_i;
        set_vec[F_WARN] = ev_err_warn_i;
        set_vec[F_PASS] = ev_err_pass_i;

        clr_vec = (wr_en_i && addr_i == A_STATUS) ? (wdata_i[NFLAG-1:0] & W1C_MASK) : '0;
        clr_vec[F_ARB]  = rd_arb;
        clr_vec[F_BERR] = rd_cod;
    end

    frerr_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .en_wr_i  (wr_en_i && addr_i == A_ENABLE),
        .en_data_i(wdata_i[NFLAG-1:0]),
        .status_o (status),
        .enable_o (enable),
        .irq_o    (irq_o)
    );

    frerr_capture #(.W(ARB_W)) u_arb_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_i  (ev_arb_lost_i),
        .data_i(arb_pos_i),
        .rd_i  (rd_arb),
        .data_o(arb_cap)
    );

    frerr_capture #(.W(DATA_W)) u_cod_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_i  (ev_bus_err_i),
        .data_i({berr_code_i, berr_state_i}),
        .rd_i  (rd_cod),
        .data_o(cod_cap)
    );

    frerr_counters u_cnt (
        .clk              (clk),
        .rst_n            (rst_n),
        .core_reset_mode_i(core_reset_mode_i),
        .bus_off_i        (ev_bus_off_i),
        .wr_tx_i          (wr_en_i && addr_i == A_TXCNT),
        .wr_rx_i          (wr_en_i && addr_i == A_RXCNT),
        .wr_lim_i         (wr_en_i && addr_i == A_WLIMIT),
        .wdata_i          (wdata_i),
        .tx_o             (tx_cnt),
        .rx_o             (rx_cnt),
        .lim_o            (lim)
    );

    always_comb begin
        case (addr_i)
            A_STATUS: rdata_o = {{(DATA_W-NFLAG){1'b0}}, status};
            A_ENABLE: rdata_o = {{(DATA_W-NFLAG){1'b0}}, enable};
            A_TXCNT:  rdata_o = tx_cnt;
            A_RXCNT:  rdata_o = rx_cnt;
            A_WLIMIT: rdata_o = lim;
            A_CODCAP: rdata_o = cod_cap;
            A_ARBCAP: rdata_o = {{(DATA_W-ARB_W){1'b0}}, arb_cap};
            default:  rdata_o = '0;
        endcase
    end

    // R4
    arb_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[F_ARB] && !rd_arb) |=> status[F_ARB]);
    // R4
    berr_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[F_BERR] && !rd_cod) |=> status[F_BERR]);
endmodule

// File: tb/sim_frerr_unit.sv
`timescale 1ns/1ps
module sim_frerr_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rmode = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       e_pbo = 0, e_arb = 0, e_berr = 0, e_boff = 0, e_warn = 0, e_pass = 0;
    logic [4:0] arb_pos = '0;
    logic [1:0] bcode = '0;
    logic [5:0] bstate = '0;
    logic       irq;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    frerr_unit u0 (
        .clk(clk), .rst_n(rst_n), .core_reset_mode_i(rmode),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata),
        .ev_prebuf_ovf_i(e_pbo), .ev_arb_lost_i(e_arb), .arb_pos_i(arb_pos),
        .ev_bus_err_i(e_berr), .berr_code_i(bcode), .berr_state_i(bstate),
        .ev_bus_off_i(e_boff), .ev_err_warn_i(e_warn), .ev_err_pass_i(e_pass),
        .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b0; #1; d = rdata;
    endtask

    task automatic rdstb(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1; #1; d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] ev, input logic [4:0] pos,
                         input logic [1:0] c, input logic [5:0] s);
        {e_pbo, e_arb, e_berr, e_boff, e_warn, e_pass} = ev;
        arb_pos = pos; bcode = c; bstate = s;
        tick();
        {e_pbo, e_arb, e_berr, e_boff, e_warn, e_pass} = '0;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        wr(3'd0, 8'hFF);
        rdstb(3'd5, d);
        rdstb(3'd6, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(3'd0, d); check("R1 status", d, 8'h00);
        peek(3'd1, d); check("R1 enable", d, 8'h00);
        peek(3'd2, d); check("R1 txcnt", d, 8'h00);
        peek(3'd3, d); check("R1 rxcnt", d, 8'h00);
        peek(3'd4, d); check("R1 limit", d, 8'h96);
        peek(3'd5, d); check("R1 codcap", d, 8'h00);
        peek(3'd6, d); check("R1 arbcap", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_bits();
        logic [7:0] d;
        for (int k = 0; k < 6; k++) begin
            pulse(6'b1 << k, 5'd1, 2'd0, 6'd0);
            peek(3'd0, d); check("R2 bit position", d, 8'h01 << k);
            clear_all();
        end
        pulse(6'h3F, 5'd3, 2'd1, 6'h02);
        peek(3'd0, d); check("R2 all set, 7:6 zero", d, 8'h3F);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        wr(3'd0, 8'hFF);
        peek(3'd0, d); check("R3 w1c leaves bits 4,3", d, 8'h18);
        rdstb(3'd4, d);
        peek(3'd0, d); check("R4 other read no clear", d, 8'h18);
        rdstb(3'd5, d);
        peek(3'd0, d); check("R4 codcap read clears berr", d, 8'h10);
        rdstb(3'd6, d);
        peek(3'd0, d); check("R4 arbcap read clears arb", d, 8'h00);
    endtask

    task automatic t_capture();
        logic [7:0] d;
        pulse(6'b01_1000, 5'd7, 2'b10, 6'h15);
        pulse(6'b01_1000, 5'd20, 2'b01, 6'h2A);
        rdstb(3'd6, d); check("R5 arbcap frozen at first", d, 8'h07);
        rdstb(3'd5, d); check("R6 codcap layout frozen", d, 8'h95);
        pulse(6'b01_1000, 5'd20, 2'b01, 6'h2A);
        rdstb(3'd6, d); check("R5 arbcap rearmed", d, 8'h14);
        rdstb(3'd5, d); check("R6 codcap rearmed", d, 8'h6A);
        peek(3'd0, d); check("R4 flags cleared", d, 8'h00);
    endtask

    task automatic t_irq();
        wr(3'd1, 8'h02);
        pulse(6'b00_0001, 5'd0, 2'd0, 6'd0);
        check("R7 masked flag no irq", {7'd0, irq}, 8'h00);
        pulse(6'b00_0010, 5'd0, 2'd0, 6'd0);
        check("R7 enabled flag irq", {7'd0, irq}, 8'h01);
        wr(3'd1, 8'h00);
        check("R7 disable drops irq", {7'd0, irq}, 8'h00);
        clear_all();
    endtask

    task automatic t_counters();
        logic [7:0] d;
        rmode = 1'b0;
        wr(3'd2, 8'h33); wr(3'd3, 8'h44);
        peek(3'd2, d); check("R8 tx locked", d, 8'h80);
        peek(3'd3, d); check("R8 rx locked", d, 8'h00);
        rmode = 1'b1;
        wr(3'd2, 8'h33); wr(3'd3, 8'h44);
        peek(3'd2, d); check("R8 tx written", d, 8'h33);
        peek(3'd3, d); check("R8 rx written", d, 8'h44);
        wr(3'd4, 8'h50);
        peek(3'd4, d); check("R11 limit", d, 8'h50);
        pulse(6'b00_0100, 5'd0, 2'd0, 6'd0);
        peek(3'd2, d); check("R9 tx preset", d, 8'h80);
        peek(3'd3, d); check("R9 rx cleared", d, 8'h00);
        addr = 3'd2; wdata = 8'h11; wr_en = 1'b1; e_boff = 1'b1;
        tick();
        wr_en = 1'b0; e_boff = 1'b0;
        peek(3'd2, d); check("R9 bus-off beats write", d, 8'h80);
        rmode = 1'b0;
        clear_all();
    endtask

    task automatic t_collide();
        logic [7:0] d;
        addr = 3'd0; wdata = 8'h20; wr_en = 1'b1; e_pbo = 1'b1;
        tick();
        wr_en = 1'b0; e_pbo = 1'b0;
        peek(3'd0, d); check("R10 set beats w1c", d, 8'h20);
        pulse(6'b01_0000, 5'd9, 2'd0, 6'd0);
        addr = 3'd6; rd_en = 1'b1; e_arb = 1'b1; arb_pos = 5'd17;
        tick();
        rd_en = 1'b0; e_arb = 1'b0;
        peek(3'd0, d); check("R10 arb flag stays", d, 8'h30);
        pulse(6'b01_0000, 5'd3, 2'd0, 6'd0);
        rdstb(3'd6, d); check("R10 capture new and frozen", d, 8'h11);
        clear_all();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bits();
        t_clear();
        t_capture();
        t_irq();
        t_counters();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule